// File: doc/BRIEF.md
# Sample-Paced Stereo Serial Audio Master

This block drives a four-wire stereo serial audio link as its clock master. It takes left/right sample pairs from an upstream packet buffer and sends each pair as one 64-slot stereo frame. While sending, it also collects a left/right pair from the serial data input. Both the bit clock and the word-select line come from this block. The format can be I2S or LSB-justified, and the word length can be 16, 18 or 20 bits.

The block has no fixed frame-rate divider. A frame begins only when the upstream buffer offers a pair. When no pair is waiting, the link goes quiet: the bit clock stays low and word-select stays high. The word-select rate therefore follows the number of samples in each 1 ms packet period, and its period is not constant.

A millisecond tick input clears a counter. The counter shows how many stereo frames have started since the last tick. Upstream logic can compare this count with the number of samples it delivered.

Top module: `aud_serial_master`

## Requirements
- R1: While reset is asserted, and after it until the first pair is accepted, bckOut is 0, wsOut is 1, sdOut is 0, rxValid is 0, txReady is 0 and frameCount is 0.
- R2: A stereo frame is 64 slots. Each slot is 2*HALF_DIV clock cycles long. bckOut is low for the first HALF_DIV cycles of a slot and high for the last HALF_DIV cycles. A frame therefore has exactly 64 rising edges and 64*HALF_DIV high cycles.
- R3: wsOut is 0 during slots 0 to 31, which carry the left channel. It is 1 during slots 32 to 63, which carry the right channel. It changes only at a slot start, while bckOut is low.
- R4: A frame starts only in a cycle where txValid is 1. In that cycle txReady is 1 and the pair is taken. With no pair offered, the link stays idle: no bckOut edges, wsOut 1, sdOut 0. A pair offered while a frame runs is taken in that frame's last cycle, and the next frame follows with no gap, so word-select falls every 128*HALF_DIV cycles.
- R5: In I2S mode (fmtLsb = 0), the sample MSB is sent in slot 1 of its channel, one bit clock after the word-select change. The remaining bits follow MSB first. All other slots carry 0.
- R6: In LSB-justified mode (fmtLsb = 1), the sample LSB is sent in slot 31 of its channel, the last slot before word-select changes. The MSB is in slot 32-N. Slots before the MSB carry 0.
- R7: wordLen selects the word length N: code 0 gives 16 bits, code 1 gives 18, and codes 2 and 3 give 20. The block sends bits N-1..0 of txLeft and txRight. fmtLsb and wordLen are sampled when a pair is taken, so a change during a frame has no effect on that frame.
- R8: sdIn is sampled while bckOut is high. It is read from the same slots that R5 and R6 use for the selected format. The received words appear on rxLeft and rxRight right-justified, with every bit above N-1 set to 0.
- R9: rxValid is a pulse of exactly one cycle. It rises two cycles after the last slot of a frame is sampled, and rxLeft/rxRight hold that frame's pair from then on.
- R10: frameCount counts the frames started since the last frameTick pulse. A tick clears it to 0. If a frame starts in the same cycle as a tick, the count becomes 1. The count saturates at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| fmtLsb | input | 1 | Framing select: 0 = I2S, 1 = LSB-justified |
| wordLen | input | 2 | Word length code (0:16, 1:18, 2/3:20) |
| txValid | input | 1 | Upstream offers a sample pair |
| txReady | output | 1 | Pair taken this cycle |
| txLeft | input | SAMPLE_W | Left sample to send, right-justified |
| txRight | input | SAMPLE_W | Right sample to send, right-justified |
| bckOut | output | 1 | Generated bit clock |
| wsOut | output | 1 | Generated word-select (0 = left) |
| sdOut | output | 1 | Serial data out |
| sdIn | input | 1 | Serial data in |
| rxValid | output | 1 | One-cycle strobe: received pair ready |
| rxLeft | output | SAMPLE_W | Received left sample, right-justified |
| rxRight | output | SAMPLE_W | Received right sample, right-justified |
| frameTick | input | 1 | 1 ms period boundary pulse |
| frameCount | output | CNT_W | Frames started since last tick |

## Verification
The bench runs both formats with several word lengths, including the aliased length code 3. It uses data patterns that expose specific faults. Alternating bits show shifts of one slot. A lone MSB or LSB set shows a reversed bit order or an offset placement. All-ones against all-zeros shows leakage into the zero-padding slots and masking errors. The incoming serial words differ from the outgoing ones, so a loopback or a swapped channel cannot match by chance. Directed runs cover idle hold, back-to-back pacing, a format change during a frame, and a tick that coincides with a frame start.

// File: rtl/aud_port_pkg.sv
package aud_port_pkg;

  localparam int SLOT_BITS  = 32;
  localparam int FRAME_SLOTS = 2 * SLOT_BITS;

  typedef enum logic {
    FMT_I2S  = 1'b0,
    FMT_LSBJ = 1'b1
  } fmt_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // pair accepted, new frame starts next cycle
    logic capture;   // first high cycle of bit clock: sample sdIn
    logic frameEnd;  // capture of the final slot of a frame
  } ctlStrobe_t;

  function automatic int wordBits(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 18;
      default: return 20;
    endcase
  endfunction

endpackage

// File: rtl/aud_port_ctrl.sv
module aud_port_ctrl
  import aud_port_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txValid,
  input  logic             frameTick,
  output logic             txReady,
  output logic             active,
  output logic [5:0]       slot,
  output logic             bckOut,
  output logic             wsOut,
  output ctlStrobe_t       stb,
  output logic [CNT_W-1:0] frameCount
);

  localparam int PH_N = 2 * HALF_DIV;
  localparam int PH_W = (PH_N > 2) ? $clog2(PH_N) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PH_N - 1);
  localparam logic [PH_W-1:0] PH_HIGH = PH_W'(HALF_DIV);

  logic [PH_W-1:0] ph;
  logic endFrame;
  logic startNow;

  assign endFrame = active && (slot == 6'(FRAME_SLOTS - 1)) && (ph == PH_LAST);
  assign startNow = txValid && (!active || endFrame);
  assign txReady  = startNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      slot   <= '0;
      ph     <= '0;
    end else if (startNow) begin
      active <= 1'b1;
      slot   <= '0;
      ph     <= '0;
    end else if (endFrame) begin
      active <= 1'b0;
      slot   <= '0;
      ph     <= '0;
    end else if (active) begin
      if (ph == PH_LAST) begin
        ph   <= '0;
        slot <= slot + 6'd1;
      end else begin
        ph <= ph + PH_W'(1);
      end
    end
  end

  assign bckOut = active && (ph >= PH_HIGH);
  assign wsOut  = active ? slot[5] : 1'b1;

  always_comb begin
    stb.load     = startNow;
    stb.capture  = active && (ph == PH_HIGH);
    stb.frameEnd = stb.capture && (slot == 6'(FRAME_SLOTS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameCount <= '0;
    end else if (frameTick) begin
      frameCount <= startNow ? CNT_W'(1) : '0;
    end else if (startNow && (frameCount != {CNT_W{1'b1}})) begin
      frameCount <= frameCount + CNT_W'(1);
    end
  end

  // R4: a frame never begins without an offered pair
  a_r4_start_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> $past(txValid));

  // R2: slot index only advances at the end of a slot
  a_r2_slot_held: assert property (@(posedge clk) disable iff (!rstN)
    (active && (ph != PH_LAST)) |=> $stable(slot));

  // R10: tick clears the frame counter
  a_r10_tick_clears: assert property (@(posedge clk) disable iff (!rstN)
    frameTick |=> (frameCount <= CNT_W'(1)));

endmodule

// File: rtl/aud_port_dpath.sv
module aud_port_dpath
  import aud_port_pkg::*;
#(
  parameter int SAMPLE_W = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          stb,
  input  logic                active,
  input  logic [5:0]          slot,
  input  logic                fmtLsb,
  input  logic [1:0]          wordLen,
  input  logic [SAMPLE_W-1:0] txLeft,
  input  logic [SAMPLE_W-1:0] txRight,
  input  logic                sdIn,
  output logic                sdOut,
  output logic                rxValid,
  output logic [SAMPLE_W-1:0] rxLeft,
  output logic [SAMPLE_W-1:0] rxRight
);

  fmt_e                fmtQ, rxFmt;
  logic [1:0]          lenQ, rxLen;
  logic [SAMPLE_W-1:0] holdL, holdR;
  logic [FRAME_SLOTS-1:0] rxBits;
  logic                doneD;
  logic                txBit;
  logic [SAMPLE_W-1:0] rxWordL, rxWordR;

  // Latch pair and framing at acceptance
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdL <= '0;
      holdR <= '0;
      fmtQ  <= FMT_I2S;
      lenQ  <= 2'd0;
    end else if (stb.load) begin
      holdL <= txLeft;
      holdR <= txRight;
      fmtQ  <= fmt_e'(fmtLsb);
      lenQ  <= wordLen;
    end
  end

  // Transmit bit for the current slot
  always_comb begin
    int pos;
    int n;
    int idx;
    logic [SAMPLE_W-1:0] w;
    pos   = int'(slot[4:0]);
    n     = wordBits(lenQ);
    w     = slot[5] ? holdR : holdL;
    idx   = -1;
    txBit = 1'b0;
    if (fmtQ == FMT_I2S) begin
      if ((pos >= 1) && (pos <= n)) idx = n - pos;
    end else if (pos >= SLOT_BITS - n) begin
      idx = SLOT_BITS - 1 - pos;
    end
    for (int k = 0; k < SAMPLE_W; k++) begin
      if (idx == k) txBit = w[k];
    end
  end

  assign sdOut = active && txBit;

  // Receive: one bit per slot, format snapshot at frame end
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxBits <= '0;
      doneD  <= 1'b0;
      rxFmt  <= FMT_I2S;
      rxLen  <= 2'd0;
    end else begin
      if (stb.capture) rxBits[slot] <= sdIn;
      doneD <= stb.frameEnd;
      if (stb.frameEnd) begin
        rxFmt <= fmtQ;
        rxLen <= lenQ;
      end
    end
  end

  always_comb begin
    int n;
    int p;
    n       = wordBits(rxLen);
    p       = 0;
    rxWordL = '0;
    rxWordR = '0;
    for (int k = 0; k < SAMPLE_W; k++) begin
      if (k < n) begin
        p = (rxFmt == FMT_I2S) ? (n - k) : (SLOT_BITS - 1 - k);
        rxWordL[k] = rxBits[p[5:0]];
        rxWordR[k] = rxBits[p[5:0] + 6'd32];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxValid <= 1'b0;
      rxLeft  <= '0;
      rxRight <= '0;
    end else begin
      rxValid <= doneD;
      if (doneD) begin
        rxLeft  <= rxWordL;
        rxRight <= rxWordR;
      end
    end
  end

  // R9: received-pair strobe lasts one cycle
  a_r9_rx_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R4: idle link drives no data
  a_r4_idle_data_low: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !sdOut);

endmodule

// File: rtl/aud_serial_master.sv
module aud_serial_master
  import aud_port_pkg::*;
#(
  parameter int SAMPLE_W = 20,
  parameter int HALF_DIV = 2,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                fmtLsb,
  input  logic [1:0]          wordLen,
  input  logic                txValid,
  output logic                txReady,
  input  logic [SAMPLE_W-1:0] txLeft,
  input  logic [SAMPLE_W-1:0] txRight,
  output logic                bckOut,
  output logic                wsOut,
  output logic                sdOut,
  input  logic                sdIn,
  output logic                rxValid,
  output logic [SAMPLE_W-1:0] rxLeft,
  output logic [SAMPLE_W-1:0] rxRight,
  input  logic                frameTick,
  output logic [CNT_W-1:0]    frameCount
);

  ctlStrobe_t stb;
  logic       active;
  logic [5:0] slot;

  aud_port_ctrl #(.HALF_DIV(HALF_DIV), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .txValid(txValid), .frameTick(frameTick),
    .txReady(txReady), .active(active), .slot(slot),
    .bckOut(bckOut), .wsOut(wsOut), .stb(stb), .frameCount(frameCount)
  );

  aud_port_dpath #(.SAMPLE_W(SAMPLE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .active(active), .slot(slot),
    .fmtLsb(fmtLsb), .wordLen(wordLen), .txLeft(txLeft), .txRight(txRight),
    .sdIn(sdIn), .sdOut(sdOut), .rxValid(rxValid),
    .rxLeft(rxLeft), .rxRight(rxRight)
  );

  // R3: word-select only moves while the bit clock is low
  a_r3_ws_fall_bck_low: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wsOut) |-> !bckOut);

  a_r3_ws_rise_bck_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wsOut) |-> !bckOut);

endmodule

// File: tb/tb_aud_serial_master.sv
module tb_aud_serial_master;

  localparam int CLK_PERIOD = 10;
  localparam int SW = 20;
  localparam int HD = 2;
  localparam int CW = 8;

  typedef struct packed {
    logic        fmt;
    logic [1:0]  len;
    logic [19:0] txL;
    logic [19:0] txR;
    logic [19:0] inL;
    logic [19:0] inR;
    logic [19:0] expL;
    logic [19:0] expR;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 20'hF1234, 20'h0ABCD, 20'h35A5A, 20'h0C3C3, 20'h05A5A, 20'h0C3C3},
    '{1'b0, 2'd1, 20'h2AAAA, 20'h15555, 20'h3FFFF, 20'h00001, 20'h3FFFF, 20'h00001},
    '{1'b0, 2'd2, 20'h80001, 20'hFFFFE, 20'h12345, 20'hEDCBA, 20'h12345, 20'hEDCBA},
    '{1'b1, 2'd0, 20'hAB00F, 20'h7FFFF, 20'h48001, 20'hC8000, 20'h08001, 20'h08000},
    '{1'b1, 2'd1, 20'h3C3C3, 20'h00000, 20'h20000, 20'h1FFFF, 20'h20000, 20'h1FFFF},
    '{1'b1, 2'd3, 20'h96969, 20'h5A5A5, 20'hFFFFF, 20'h80000, 20'hFFFFF, 20'h80000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fmtLsb = 1'b0;
  logic [1:0] wordLen = 2'd0;
  logic txValid = 1'b0;
  logic txReady;
  logic [SW-1:0] txLeft = '0;
  logic [SW-1:0] txRight = '0;
  logic bckOut, wsOut, sdOut;
  logic sdIn = 1'b0;
  logic rxValid;
  logic [SW-1:0] rxLeft, rxRight;
  logic frameTick = 1'b0;
  logic [CW-1:0] frameCount;

  aud_serial_master #(.SAMPLE_W(SW), .HALF_DIV(HD), .CNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .fmtLsb(fmtLsb), .wordLen(wordLen),
    .txValid(txValid), .txReady(txReady), .txLeft(txLeft), .txRight(txRight),
    .bckOut(bckOut), .wsOut(wsOut), .sdOut(sdOut), .sdIn(sdIn),
    .rxValid(rxValid), .rxLeft(rxLeft), .rxRight(rxRight),
    .frameTick(frameTick), .frameCount(frameCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nFail = 0;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference slot placement, written from R5/R6/R7
  function automatic logic refBit(input logic fmt, input logic [1:0] len,
                                  input logic [19:0] l, input logic [19:0] r,
                                  input int s);
    int n;
    int p;
    logic [19:0] w;
    n = (len == 2'd0) ? 16 : (len == 2'd1) ? 18 : 20;
    p = s % 32;
    w = (s >= 32) ? r : l;
    if (s < 0 || s > 63) return 1'b0;
    if (!fmt) begin
      if (p >= 1 && p <= n) return w[n-p];
    end else if (p >= 32 - n) begin
      return w[31-p];
    end
    return 1'b0;
  endfunction

  // Slave-side monitor and serial source
  logic curFmt = 1'b0;
  logic [1:0] curLen = 2'd0;
  logic [19:0] inL = '0, inR = '0;
  logic [63:0] capTx = '0, capWs = '0;
  logic prevBck = 1'b0, prevWs = 1'b1;
  int r = 0;
  int riseCount = 0;
  int highCyc = 0;
  int cyc = 0;
  int lastFall = 0;
  int fallGap = 0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (prevWs && !wsOut) begin
        r = 0;
        fallGap = cyc - lastFall;
        lastFall = cyc;
        sdIn = refBit(curFmt, curLen, inL, inR, 0);
      end else if (prevBck && !bckOut) begin
        sdIn = refBit(curFmt, curLen, inL, inR, r);
      end
      if (!prevBck && bckOut) begin
        if (r < 64) begin
          capTx[r] = sdOut;
          capWs[r] = wsOut;
        end
        r++;
        riseCount++;
      end
      if (bckOut) highCyc++;
    end
    prevBck = bckOut;
    prevWs = wsOut;
  end

  task automatic sendPair(input logic [19:0] l, input logic [19:0] rr);
    @(negedge clk);
    txValid = 1'b1;
    txLeft = l;
    txRight = rr;
    #1;
    while (!txReady) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic runVec(input vec_t v);
    int rise0;
    int high0;
    logic [63:0] expTx;
    curFmt = v.fmt; curLen = v.len; inL = v.inL; inR = v.inR;
    fmtLsb = v.fmt; wordLen = v.len;
    capTx = '0; capWs = '1;
    rise0 = riseCount; high0 = highCyc;
    sendPair(v.txL, v.txR);
    // R7: change framing mid-frame, must not affect this frame
    fmtLsb = ~v.fmt; wordLen = ~v.len;
    do @(negedge clk); while (!rxValid);
    check("R8", "rx pair", 64'({rxLeft, rxRight}), 64'({v.expL, v.expR}));
    @(negedge clk);
    check("R9", "rxValid one cycle", 64'(rxValid), 64'd0);
    for (int s = 0; s < 64; s++) expTx[s] = refBit(v.fmt, v.len, v.txL, v.txR, s);
    check(v.fmt ? "R6" : "R5", "tx slots (R7 length)", capTx, expTx);
    check("R3", "ws per slot", capWs, 64'hFFFFFFFF_00000000);
    check("R2", "bck rises per frame", 64'(riseCount - rise0), 64'd64);
    check("R2", "bck high cycles", 64'(highCyc - high0), 64'(64 * HD));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    int rise0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", "outputs in reset",
          64'({bckOut, wsOut, sdOut, rxValid, txReady}), 64'b01000);
    check("R1", "count in reset", 64'(frameCount), 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "outputs after reset",
          64'({bckOut, wsOut, sdOut, rxValid, frameCount}), 64'h400);

    for (int i = 0; i < NV; i++) runVec(VECS[i]);

    // R10: frames since tick
    check("R10", "count after vectors", 64'(frameCount), 64'(NV));

    // R4: idle hold with no pair offered
    rise0 = riseCount;
    repeat (40) @(negedge clk);
    check("R4", "idle no bck edges", 64'(riseCount - rise0), 64'd0);
    check("R4", "idle ws/sd/ready", 64'({wsOut, sdOut, txReady}), 64'b100);

    // R10: tick clears
    frameTick = 1'b1;
    @(negedge clk);
    frameTick = 1'b0;
    @(negedge clk);
    check("R10", "count cleared by tick", 64'(frameCount), 64'd0);

    // R4: back-to-back frames, no gap
    curFmt = 1'b0; curLen = 2'd2; fmtLsb = 1'b0; wordLen = 2'd2;
    sendPair(20'h11111, 20'h22222);
    sendPair(20'h33333, 20'h44444);
    do @(negedge clk); while (!rxValid);
    check("R4", "ws fall spacing back-to-back", 64'(fallGap), 64'(128 * HD));
    check("R10", "count after two frames", 64'(frameCount), 64'd2);
    repeat (20) @(negedge clk);

    // R10: tick in the same cycle as a frame start
    @(negedge clk);
    txValid = 1'b1; frameTick = 1'b1;
    #1;
    check("R4", "txReady when idle and valid", 64'(txReady), 64'd1);
    @(negedge clk);
    txValid = 1'b0; frameTick = 1'b0;
    check("R10", "tick coinciding with start", 64'(frameCount), 64'd1);
    do @(negedge clk); while (!rxValid);
    repeat (4) @(negedge clk);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule